// File: doc/BRIEF.md
# Serial ADC Frame Controller

This block is the host side of a link to a 12-bit successive-approximation converter with a three-wire serial port. On a command it lowers chip select and produces a serial clock from the system clock. It counts the serial clock cycles of the frame and samples the converter's data line once in each cycle. At the end of the frame it raises chip select, keeps it high for a programmable gap, and then accepts the next command.

The converter sends a zero first and then the 12 result bits, most significant first. After a conversion frame the controller removes the framing bits, presents the 12-bit code with a one-cycle valid strobe, and flags a framing error when the first bit is not zero. A sleep command ends the frame after four serial clock cycles, which puts the converter into power-down. A wake command runs a complete frame and discards its data, so the frame after it returns a valid result. Conversion and wake frames have 16 cycles, or 14 cycles when the short-frame input is set.

Top module: `adc_spi_master`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `adc_cs_n` and `adc_sclk` are 1, `cmd_ready` is 1, and `sample_valid` is 0.
- R2: Each serial clock phase, high or low, lasts H system clocks, where H = `sclk_div` >> 1, and H is 1 when that value is 0. `adc_sclk` is 1 whenever `adc_cs_n` is 1.
- R3: Conversion and wake frames give 16 falling edges of `adc_sclk` while `adc_cs_n` is low when `short_frame` is 0, and 14 when it is 1.
- R4: Op codes 2'b00 (convert) and 2'b11 (treated as convert) produce one `sample_valid` pulse of one cycle, in the cycle in which `adc_cs_n` rises. `sample_code` holds the bits sampled on rising edges 2 to 13, first bit as MSB.
- R5: `sample_err` is updated with each valid sample and is 1 when the bit sampled on rising edge 1 was 1.
- R6: Op code 2'b01 (sleep) gives exactly 4 falling edges of `adc_sclk`, then raises `adc_cs_n` and produces no `sample_valid`.
- R7: Op code 2'b10 (wake) runs a frame of full length and produces no `sample_valid`.
- R8: `cmd_ready` is low from the cycle after a command is accepted until the gap has ended. A `cmd_valid` that arrives while `cmd_ready` is low starts no frame.
- R9: When commands follow back to back, `adc_cs_n` stays high for exactly `idle_gap` + 2 system clocks between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Command code: convert, sleep, wake |
| cmd_ready | output | 1 | High when idle; a command is accepted when both `cmd_valid` and `cmd_ready` are high |
| short_frame | input | 1 | Selects the 14-cycle frame length |
| sclk_div | input | DIV_W | System clocks per serial clock period |
| idle_gap | input | GAP_W | Extra chip-select high time between frames |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Chip select to the converter, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| sample_valid | output | 1 | One-cycle strobe when a new result is ready |
| sample_code | output | 12 | Conversion result |
| sample_err | output | 1 | Framing error for the current result |

## Verification
The hardest case to create is a command that arrives while a frame is still running. That request must be dropped, and the frame must not be cut short. The bench holds a sleep request on `cmd_valid` for one cycle in the middle of a 16-cycle conversion frame. It then checks that exactly one frame with 16 falling edges and one valid sample took place. The bench also keeps `cmd_valid` high through one whole frame, so that the next command is accepted in the first cycle possible. This exposes the exact chip-select high time, and the bench compares it with `idle_gap` + 2.

// File: rtl/adc_spi_pkg.sv
package adc_spi_pkg;
    localparam int SAMPLE_W  = 12;
    localparam int CAP_BITS  = SAMPLE_W + 1;
    localparam int FULL_LEN  = 16;
    localparam int SHORT_LEN = 14;
    localparam int SLEEP_LEN = 4;
    localparam int LEN_W     = $clog2(FULL_LEN + 1);

    typedef enum logic [1:0] {
        OP_CONVERT = 2'b00,
        OP_SLEEP   = 2'b01,
        OP_WAKE    = 2'b10,
        OP_RSVD    = 2'b11
    } op_e;

    typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_GAP} state_e;

    typedef struct packed {
        logic                lead_err;
        logic [SAMPLE_W-1:0] code;
    } result_t;

    function automatic logic [LEN_W-1:0] frame_len(op_e op, logic short_f);
        if (op == OP_SLEEP)
            return LEN_W'(SLEEP_LEN);
        else if (short_f)
            return LEN_W'(SHORT_LEN);
        else
            return LEN_W'(FULL_LEN);
    endfunction

    function automatic logic returns_data(op_e op);
        return (op == OP_CONVERT) || (op == OP_RSVD);
    endfunction
endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             hold,
    input  logic [DIV_W-1:0] sclk_div,
    output logic             sclk,
    output logic             rise_tick,
    output logic             hi_end
);
    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] cnt;
    logic             phase_end;

    always_comb begin
        half = sclk_div >> 1;
        if (half == '0)
            half = DIV_W'(1);
    end

    assign phase_end = (cnt == half - DIV_W'(1));
    assign rise_tick = en && phase_end && !sclk;
    assign hi_end    = en && phase_end && sclk;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt  <= '0;
            sclk <= 1'b1;
        end else if (phase_end) begin
            cnt <= '0;
            if (!sclk)
                sclk <= 1'b1;
            else if (!hold)
                sclk <= 1'b0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/adc_capture.sv
module adc_capture #(
    parameter int BITS = 13
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            shift_en,
    input  logic            sdo,
    output logic [BITS-1:0] bits
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            bits <= '0;
        else if (shift_en)
            bits <= {bits[BITS-2:0], sdo};
    end
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
    import adc_spi_pkg::*;
#(
    parameter int GAP_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic                short_frame,
    input  logic [GAP_W-1:0]    idle_gap,
    input  logic                rise_tick,
    input  logic                hi_end,
    input  logic [CAP_BITS-1:0] cap_bits,
    output logic                cmd_ready,
    output logic                cs_n,
    output logic                sclk_en,
    output logic                hold,
    output logic                shift_en,
    output logic                cap_clear,
    output logic                res_valid,
    output result_t             result
);
    state_e           state;
    op_e              op_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] fcnt;
    logic [GAP_W-1:0] gcnt;
    logic             accept;

    assign cmd_ready = (state == ST_IDLE);
    assign accept    = cmd_ready && cmd_valid;
    assign cap_clear = accept;
    assign sclk_en   = (state == ST_FRAME);
    assign hold      = (fcnt == len_q);
    assign shift_en  = sclk_en && rise_tick && (fcnt <= LEN_W'(CAP_BITS));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            op_q      <= OP_CONVERT;
            len_q     <= '0;
            fcnt      <= '0;
            gcnt      <= '0;
            cs_n      <= 1'b1;
            res_valid <= 1'b0;
            result    <= '0;
        end else begin
            res_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        op_q  <= op_e'(cmd_op);
                        len_q <= frame_len(op_e'(cmd_op), short_frame);
                        fcnt  <= '0;
                        cs_n  <= 1'b0;
                        state <= ST_FRAME;
                    end
                end
                ST_FRAME: begin
                    if (hi_end) begin
                        if (fcnt == len_q) begin
                            cs_n  <= 1'b1;
                            gcnt  <= idle_gap;
                            state <= ST_GAP;
                            if (returns_data(op_q)) begin
                                res_valid       <= 1'b1;
                                result.lead_err <= cap_bits[CAP_BITS-1];
                                result.code     <= cap_bits[SAMPLE_W-1:0];
                            end
                        end else begin
                            fcnt <= fcnt + LEN_W'(1);
                        end
                    end
                end
                ST_GAP: begin
                    if (gcnt == '0)
                        state <= ST_IDLE;
                    else
                        gcnt <= gcnt - GAP_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_spi_master.sv
module adc_spi_master
    import adc_spi_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int GAP_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    output logic                cmd_ready,
    input  logic                short_frame,
    input  logic [DIV_W-1:0]    sclk_div,
    input  logic [GAP_W-1:0]    idle_gap,
    input  logic                adc_sdo,
    output logic                adc_cs_n,
    output logic                adc_sclk,
    output logic                sample_valid,
    output logic [SAMPLE_W-1:0] sample_code,
    output logic                sample_err
);
    logic                sclk_en, hold, rise_tick, hi_end;
    logic                shift_en, cap_clear;
    logic [CAP_BITS-1:0] cap_bits;
    result_t             result;

    adc_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
        .clk(clk), .rst(rst), .en(sclk_en), .hold(hold), .sclk_div(sclk_div),
        .sclk(adc_sclk), .rise_tick(rise_tick), .hi_end(hi_end)
    );

    adc_capture #(.BITS(CAP_BITS)) u_cap (
        .clk(clk), .rst(rst), .clear(cap_clear), .shift_en(shift_en),
        .sdo(adc_sdo), .bits(cap_bits)
    );

    adc_frame_ctrl #(.GAP_W(GAP_W)) u_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .short_frame(short_frame), .idle_gap(idle_gap), .rise_tick(rise_tick),
        .hi_end(hi_end), .cap_bits(cap_bits), .cmd_ready(cmd_ready),
        .cs_n(adc_cs_n), .sclk_en(sclk_en), .hold(hold), .shift_en(shift_en),
        .cap_clear(cap_clear), .res_valid(sample_valid), .result(result)
    );

    assign sample_code = result.code;
    assign sample_err  = result.lead_err;
endmodule

// File: rtl/adc_spi_master_chk.sv
module adc_spi_master_chk (
    input logic clk,
    input logic rst,
    input logic cmd_ready,
    input logic adc_cs_n,
    input logic adc_sclk,
    input logic sample_valid
);
    logic [5:0] fc;
    logic       sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fc     <= '0;
            sclk_q <= 1'b1;
        end else begin
            sclk_q <= adc_sclk;
            if (adc_cs_n)
                fc <= '0;
            else if (sclk_q && !adc_sclk)
                fc <= fc + 6'd1;
        end
    end

    assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (rst)
        adc_cs_n |-> adc_sclk);
    assert_frame_len_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_cs_n) |-> (fc == 6'd16 || fc == 6'd14 || fc == 6'd4));
    assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid);
    assert_valid_at_end_R4: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> $rose(adc_cs_n));
    assert_sleep_silent_R6: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> fc >= 6'd14);
    assert_busy_R8: assert property (@(posedge clk) disable iff (rst)
        !adc_cs_n |-> !cmd_ready);
endmodule

bind adc_spi_master adc_spi_master_chk u_chk (
    .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .adc_cs_n(adc_cs_n),
    .adc_sclk(adc_sclk), .sample_valid(sample_valid)
);

// File: tb/adc_spi_master_tb.sv
module adc_spi_master_tb;
    typedef struct packed {
        logic [1:0]  op;
        logic        short_f;
        logic [7:0]  div;
        logic [7:0]  gap;
        logic [11:0] code;
        logic        lead;
        logic [4:0]  falls;
        logic        valid;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 8'd4, 8'd2, 12'hA5C, 1'b0, 5'd16, 1'b1},
        '{2'd0, 1'b1, 8'd2, 8'd0, 12'h3F1, 1'b0, 5'd14, 1'b1},
        '{2'd0, 1'b0, 8'd6, 8'd1, 12'hFFF, 1'b1, 5'd16, 1'b1},
        '{2'd1, 1'b0, 8'd4, 8'd1, 12'h123, 1'b0, 5'd4,  1'b0},
        '{2'd2, 1'b0, 8'd4, 8'd1, 12'h777, 1'b0, 5'd16, 1'b0},
        '{2'd0, 1'b0, 8'd3, 8'd0, 12'h000, 1'b0, 5'd16, 1'b1},
        '{2'd3, 1'b1, 8'd8, 8'd0, 12'h801, 1'b0, 5'd14, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic        short_frame = 1'b0;
    logic [7:0]  sclk_div = 8'd4;
    logic [7:0]  idle_gap = 8'd0;
    logic        adc_sdo = 1'b0;
    logic        cmd_ready, adc_cs_n, adc_sclk, sample_valid, sample_err;
    logic [11:0] sample_code;

    int          ntests = 0, nfail = 0;
    bit          done = 1'b0;
    logic [11:0] m_code = '0;
    logic        m_lead = 1'b0;
    int          mf = 0, fstart = 0, frames = 0, last_falls = 0;
    int          lowc = 0, hirun = 0, last_gap = 0, vcnt = 0;
    logic [11:0] got_code = '0;
    logic        got_err = 1'b0;
    logic        cs_prev = 1'b1;

    always #2 clk = ~clk;

    adc_spi_master u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_ready(cmd_ready), .short_frame(short_frame), .sclk_div(sclk_div),
        .idle_gap(idle_gap), .adc_sdo(adc_sdo), .adc_cs_n(adc_cs_n),
        .adc_sclk(adc_sclk), .sample_valid(sample_valid),
        .sample_code(sample_code), .sample_err(sample_err)
    );

    // converter model: new bit after each falling edge of the serial clock
    always @(negedge adc_sclk) begin
        if (adc_cs_n === 1'b0) begin
            mf = mf + 1;
            if (mf - fstart == 1)
                adc_sdo = m_lead;
            else if (mf - fstart >= 2 && mf - fstart <= 13)
                adc_sdo = m_code[13 - (mf - fstart)];
            else
                adc_sdo = 1'b0;
        end
    end

    // monitor: sample away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (cs_prev && !adc_cs_n) begin
                fstart = mf;
                frames = frames + 1;
                lowc   = 0;
                if (hirun != 0) last_gap = hirun;
                hirun  = 0;
            end
            if (!cs_prev && adc_cs_n)
                last_falls = mf - fstart;
            if (!adc_cs_n && !adc_sclk) lowc = lowc + 1;
            if (adc_cs_n) hirun = hirun + 1;
            if (sample_valid) begin
                vcnt     = vcnt + 1;
                got_code = sample_code;
                got_err  = sample_err;
            end
            cs_prev = adc_cs_n;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op);
        bit ok;
        cmd_op    = op;
        cmd_valid = 1'b1;
        forever begin
            ok = cmd_ready;
            @(negedge clk);
            if (ok) break;
        end
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!cmd_ready || !adc_cs_n) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            ntests++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: values while reset is high and in the first cycle after release
        chk(adc_cs_n === 1'b1 && adc_sclk === 1'b1, "R1 lines in reset", adc_cs_n, 1);
        chk(cmd_ready === 1'b1 && sample_valid === 1'b0, "R1 handshake in reset", cmd_ready, 1);
        rst = 1'b0;
        @(negedge clk);
        chk(adc_cs_n === 1'b1 && adc_sclk === 1'b1, "R1 lines after reset", adc_sclk, 1);
        chk(cmd_ready === 1'b1 && sample_valid === 1'b0, "R1 handshake after reset", sample_valid, 0);

        for (int i = 0; i < NV; i++) begin
            int v0, half;
            short_frame = VECS[i].short_f;
            sclk_div    = VECS[i].div;
            idle_gap    = VECS[i].gap;
            m_code      = VECS[i].code;
            m_lead      = VECS[i].lead;
            half        = (VECS[i].div >> 1) == 0 ? 1 : (VECS[i].div >> 1);
            v0          = vcnt;
            issue(VECS[i].op);
            wait_idle();
            // R3 R6 R7: falling edges in the frame
            chk(last_falls == int'(VECS[i].falls), "R3/R6 falling edge count", last_falls, VECS[i].falls);
            // R2: time the clock spends low
            chk(lowc == int'(VECS[i].falls) * half, "R2 low phase length", lowc, int'(VECS[i].falls) * half);
            // R4 R6 R7: number of valid strobes
            chk(vcnt - v0 == int'(VECS[i].valid), "R4/R7 valid strobe count", vcnt - v0, VECS[i].valid);
            if (VECS[i].valid) begin
                chk(got_code == VECS[i].code, "R4 sample code", got_code, VECS[i].code);
                chk(got_err == VECS[i].lead, "R5 framing error flag", got_err, VECS[i].lead);
            end
        end

        // R8: sleep request while a conversion frame is running is dropped
        begin
            int f0, v0;
            sclk_div = 8'd4; short_frame = 1'b0; idle_gap = 8'd1;
            m_code = 12'h5A5; m_lead = 1'b0;
            f0 = frames; v0 = vcnt;
            issue(2'd0);
            repeat (10) @(negedge clk);
            cmd_op = 2'd1; cmd_valid = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
            wait_idle();
            repeat (10) @(negedge clk);
            chk(frames - f0 == 1, "R8 frames started", frames - f0, 1);
            chk(last_falls == 16, "R8 frame not shortened", last_falls, 16);
            chk(vcnt - v0 == 1 && got_code == 12'h5A5, "R8 sample delivered", got_code, 12'h5A5);
        end

        // R9: back-to-back commands give idle_gap + 2 cycles of chip select high
        begin
            idle_gap = 8'd3; sclk_div = 8'd2;
            issue(2'd0);
            issue(2'd0);
            wait_idle();
            chk(last_gap == 5, "R9 chip select high time", last_gap, 5);
            idle_gap = 8'd0;
            issue(2'd0);
            issue(2'd0);
            wait_idle();
            chk(last_gap == 2, "R9 minimum high time", last_gap, 2);
        end

        // R2: a divider of 0 is treated as one system clock per phase
        sclk_div = 8'd0;
        issue(2'd0);
        wait_idle();
        chk(lowc == 16, "R2 divider zero", lowc, 16);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule